// File: doc/BRIEF.md
# Horizontal Sync and Clamp Pulse Generator

This block turns a line-phase reference into the two timing pulses a video front end needs on every line: a horizontal drive pulse whose rising edge marks the start of the line sync, and a clamp (burst-key) pulse that opens a window on the back porch a fixed delay after that edge. The reference runs at twice the line rate. A strobe from the locked line counter re-phases it, and an internal half-line counter keeps it ticking when no strobe arrives. A toggle flip-flop lets only every second reference tick start a line.

Pulse shaping and timing are covered here; the phase-locking loop that produces the strobe is not. Every duration is a parameter counted in clock cycles. The defaults suit a 27 MHz sample clock: 858 cycles per half line (about 15734 Hz line rate), a 146-cycle horizontal pulse (about 5.4 µs), a clamp pulse that starts 146 cycles after the sync edge and lasts 92 cycles (about 3.4 µs), and a 644-cycle guard during which early strobes are ignored.

Top module: `hline_pulse_gen`

## Requirements
- R1: With `rst` high at a clock edge, both outputs are low after that edge. The half-line counter is loaded so that the first strobe after reset is accepted at once. The line toggle is cleared, so the first reference tick after reset starts a line.
- R2: A reference tick is taken from `ref_strobe` only when at least MIN_GAP+1 (default 645) clock edges have passed since the previous tick. A strobe sampled sooner is ignored and produces no pulse.
- R3: When no strobe is accepted, a reference tick is generated FREE_CYC (default 858) edges after the previous tick.
- R4: Reference ticks alternate between line starts and mid-line ticks, beginning with a line start after reset.
- R5: On a line-start tick, `hsync_o` rises one edge after the edge that sampled the strobe, and stays high for HS_WIDTH (default 146) cycles.
- R6: `clamp_o` rises CLAMP_DELAY (default 146) cycles after the rising edge of `hsync_o` and stays high for CLAMP_WIDTH (default 92) cycles. With the defaults the two pulses never overlap.
- R7: A mid-line tick leaves both outputs low.
- R8: Without any strobe, both pulses keep running with a horizontal period of 2*FREE_CYC cycles (default 1716) and unchanged widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_strobe | input | 1 | Twice-line-rate phase strobe from the locked line counter |
| hsync_o | output | 1 | Horizontal drive pulse, registered |
| clamp_o | output | 1 | Back-porch clamp pulse, registered |

## Verification
The assertions assume that accepted reference ticks are always spaced far enough apart that a line-start tick never arrives while the previous pulse pair is still running. They also assume that reset is applied synchronously. The guard window makes the spacing hold for any strobe pattern. The stimulus still keeps its strobe gaps at or above the guard, or exactly at the free-running boundary, apart from the entries meant to be ignored. It raises reset only on clock-edge-aligned negative half cycles, so the timer length checks are never cut short, except at the one reset-mid-pulse point that the checks exclude.

// File: rtl/hlp_pkg.sv
package hlp_pkg;

  typedef enum logic [1:0] {
    PT_IDLE   = 2'd0,
    PT_WAIT   = 2'd1,
    PT_ACTIVE = 2'd2
  } pt_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // counter width able to hold values 0..n-1, never below one bit
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/hlp_ref_tracker.sv
module hlp_ref_tracker
  import hlp_pkg::*;
#(
  parameter int unsigned FREE_CYC = 858,
  parameter int unsigned MIN_GAP  = 644
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_strobe,
  output logic tick
);
  localparam int unsigned CW = cnt_bits(FREE_CYC);
  localparam logic [CW-1:0] GAP_LIM  = CW'(MIN_GAP);
  localparam logic [CW-1:0] FREE_LIM = CW'(FREE_CYC - 1);

  logic [CW-1:0] since_q;
  logic          tick_q;
  logic          accept;
  logic          expire;

  assign accept = ref_strobe && (since_q >= GAP_LIM);
  assign expire = (since_q == FREE_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= GAP_LIM;
      tick_q  <= 1'b0;
    end else if (accept || expire) begin
      since_q <= '0;
      tick_q  <= 1'b1;
    end else begin
      since_q <= since_q + 1'b1;
      tick_q  <= 1'b0;
    end
  end

  assign tick = tick_q;

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);

  // R3
  free_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (since_q == FREE_LIM) |=> tick_q);

endmodule

// File: rtl/hlp_line_phase.sv
module hlp_line_phase (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic line_go
);
  logic odd_q;

  always_ff @(posedge clk) begin
    if (rst)       odd_q <= 1'b0;
    else if (tick) odd_q <= ~odd_q;
  end

  assign line_go = tick && !odd_q;

  // R4
  mid_tick_chk: assert property (@(posedge clk) disable iff (rst)
    line_go |=> !line_go);

endmodule

// File: rtl/hlp_pulse_timer.sv
module hlp_pulse_timer
  import hlp_pkg::*;
#(
  parameter int unsigned DELAY = 0,
  parameter int unsigned WIDTH = 146
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic pulse
);
  localparam int unsigned CW = cnt_bits(max2(DELAY, WIDTH));
  localparam bit HAS_DELAY = (DELAY > 0);
  localparam logic [CW-1:0] DLY_LOAD = HAS_DELAY ? CW'(DELAY - 1) : '0;
  localparam logic [CW-1:0] WID_LOAD = CW'(WIDTH - 1);

  pt_state_e     st_q;
  logic [CW-1:0] left_q;
  logic          out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PT_IDLE;
      left_q <= '0;
      out_q  <= 1'b0;
    end else if (start) begin
      if (HAS_DELAY) begin
        st_q   <= PT_WAIT;
        left_q <= DLY_LOAD;
        out_q  <= 1'b0;
      end else begin
        st_q   <= PT_ACTIVE;
        left_q <= WID_LOAD;
        out_q  <= 1'b1;
      end
    end else begin
      unique case (st_q)
        PT_WAIT: begin
          if (left_q == '0) begin
            st_q   <= PT_ACTIVE;
            left_q <= WID_LOAD;
            out_q  <= 1'b1;
          end else begin
            left_q <= left_q - 1'b1;
          end
        end
        PT_ACTIVE: begin
          if (left_q == '0) begin
            st_q  <= PT_IDLE;
            out_q <= 1'b0;
          end else begin
            left_q <= left_q - 1'b1;
          end
        end
        default: begin
          st_q  <= PT_IDLE;
          out_q <= 1'b0;
        end
      endcase
    end
  end

  assign pulse = out_q;

  // independent length meter for the width check
  logic [CW:0] hi_len_q;
  always_ff @(posedge clk) begin
    if (rst)        hi_len_q <= '0;
    else if (out_q) hi_len_q <= hi_len_q + 1'b1;
    else            hi_len_q <= '0;
  end

  // R5 R6
  width_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(out_q) && !$past(rst)) |-> (hi_len_q == (CW+1)'(WIDTH)));

endmodule

// File: rtl/hline_pulse_gen.sv
module hline_pulse_gen
  import hlp_pkg::*;
#(
  parameter int unsigned FREE_CYC    = 858,
  parameter int unsigned MIN_GAP     = 644,
  parameter int unsigned HS_WIDTH    = 146,
  parameter int unsigned CLAMP_DELAY = 146,
  parameter int unsigned CLAMP_WIDTH = 92
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_strobe,
  output logic hsync_o,
  output logic clamp_o
);
  // clamp delay is counted from the sync rising edge, i.e. one edge after start
  localparam int unsigned CL_START_DLY = CLAMP_DELAY;

  logic tick;
  logic line_go;

  hlp_ref_tracker #(
    .FREE_CYC (FREE_CYC),
    .MIN_GAP  (MIN_GAP)
  ) u_ref (
    .clk        (clk),
    .rst        (rst),
    .ref_strobe (ref_strobe),
    .tick       (tick)
  );

  hlp_line_phase u_phase (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .line_go (line_go)
  );

  hlp_pulse_timer #(
    .DELAY (0),
    .WIDTH (HS_WIDTH)
  ) u_hs (
    .clk   (clk),
    .rst   (rst),
    .start (line_go),
    .pulse (hsync_o)
  );

  hlp_pulse_timer #(
    .DELAY (CL_START_DLY),
    .WIDTH (CLAMP_WIDTH)
  ) u_cl (
    .clk   (clk),
    .rst   (rst),
    .start (line_go),
    .pulse (clamp_o)
  );

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always @(posedge clk) begin
    if (rst_d) begin
      reset_low_chk: assert (!hsync_o && !clamp_o);
    end
  end

  // R5
  hs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_o) |-> $past(line_go));

  generate
    if (CLAMP_DELAY >= HS_WIDTH) begin : g_sep
      // R6
      no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(hsync_o && clamp_o));
    end
  endgenerate

endmodule

// File: tb/hline_pulse_gen_bench.sv
module hline_pulse_gen_bench;
  localparam int FREE = 858;
  localparam int HW   = 146;
  localparam int CD   = 146;
  localparam int CWD  = 92;
  localparam int NV   = 12;
  // strobe gap from previous strobe (entry 0: from reset release); expected line start
  localparam int GAP_T  [NV] = '{10, 858, 858, 858, 400, 458, 850, 858, 645, 644, 214, 858};
  localparam bit LINE_T [NV] = '{1,  0,   1,   0,   0,   1,   0,   1,   0,   0,   1,   0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_strobe = 1'b0;
  logic hsync_o, clamp_o;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  int h_rises = 0, c_rises = 0;
  int h_rise = -1, h_prev_rise = -1, h_wid = -1, c_rise = -1, c_wid = -1;
  logic h_d = 1'b0, c_d = 1'b0;

  hline_pulse_gen u_hline_pulse_gen (
    .clk(clk), .rst(rst), .ref_strobe(ref_strobe), .hsync_o(hsync_o), .clamp_o(clamp_o));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (hsync_o && !h_d) begin h_prev_rise = h_rise; h_rise = cyc; h_rises++; end
    if (!hsync_o && h_d) h_wid = cyc - h_rise;
    if (clamp_o && !c_d) begin c_rise = cyc; c_rises++; end
    if (!clamp_o && c_d) c_wid = cyc - c_rise;
    h_d = hsync_o;
    c_d = clamp_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // strobe sampled at the edge where cyc becomes tgt
  task automatic strobe_at(input int tgt);
    wait_to(tgt - 1);
    ref_strobe = 1'b1;
    @(negedge clk);
    ref_strobe = 1'b0;
  endtask

  task automatic line_checks(input int s);
    chk("R5 hsync rise cycle", h_rise, s + 1);
    chk("R5 hsync width", h_wid, HW);
    chk("R6 clamp rise cycle", c_rise, s + 1 + CD);
    chk("R6 clamp width", c_wid, CWD);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int s, base, hr0, cr0;
    repeat (4) @(negedge clk);
    chk("R1 hsync low in reset", int'(hsync_o), 0);
    chk("R1 clamp low in reset", int'(clamp_o), 0);
    rst = 1'b0;
    base = cyc;
    s = base;
    // table walk: R2 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      hr0 = h_rises;
      cr0 = c_rises;
      strobe_at(s + GAP_T[i]);
      s = s + GAP_T[i];
      if (LINE_T[i]) begin
        wait_to(s + 250);
        chk("R4 line start pulse count", h_rises, hr0 + 1);
        line_checks(s);
      end else begin
        wait_to(s + 100);
        chk("R7 R2 no hsync on this strobe", h_rises, hr0);
        chk("R7 R2 no clamp on this strobe", c_rises, cr0);
      end
    end
    // free running: R3 R8
    wait_to(s + 3 * FREE + 300);
    chk("R8 R3 free-run hsync rise", h_rise, s + 3 * FREE + 1);
    chk("R8 free-run hsync period", h_rise - h_prev_rise, 2 * FREE);
    chk("R8 free-run hsync width", h_wid, HW);
    chk("R8 free-run clamp rise", c_rise, s + 3 * FREE + 1 + CD);
    chk("R8 free-run clamp width", c_wid, CWD);
    // reset while hsync is high: R1
    wait_to(s + 5 * FREE + 50);
    chk("R1 hsync high before reset", int'(hsync_o), 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 hsync cleared by reset", int'(hsync_o), 0);
    chk("R1 clamp cleared by reset", int'(clamp_o), 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    s = cyc;
    hr0 = h_rises;
    strobe_at(s + 5);
    s = s + 5;
    wait_to(s + 250);
    chk("R1 first tick after reset is a line", h_rises, hr0 + 1);
    line_checks(s);
    hr0 = h_rises;
    strobe_at(s + FREE);
    s = s + FREE;
    wait_to(s + 100);
    chk("R4 second tick after reset is mid-line", h_rises, hr0);
    done = 1'b1;
    summary();
  end
endmodule